// File: doc/BRIEF.md
# Probe-Driven Debug Register Bank

This block holds a small bank of configuration and status words that a host reaches through a virtual debug probe instead of a processor bus. The host drives one packed write word. The upper half of that word is the target register address and the lower half is the value to store. The probe gives no write strobe, so the bank treats any change in the packed word as a new write command. It commits that write exactly once and ignores the word for as long as it stays the same.

Reads use a separate address input. The addressed register appears on a registered read-data output one clock later. A reset puts every register at zero. The first write word seen after reset serves only as the reference for change detection, so whatever power-up value the probe happens to drive never lands in the bank.

Top module: `probe_regbank`

## Requirements
- R1: The bank holds 32 registers of 32 bits. In the 64-bit write word, bits 63:32 are the register address and bits 31:0 are the data. A committed write stores the data into the addressed register.
- R2: The read-data output is registered. It shows the register selected by the read address one clock edge after that address is applied, and it keeps its old value until that edge.
- R3: A write is committed in the single cycle in which the write word differs from its value at the previous clock edge. A change in the data field alone also commits. A word that is held constant never commits again.
- R4: The write word sampled at the first clock edge after reset is taken as the reference value only. It causes no write, even when it holds a valid address and nonzero data.
- R5: A write whose address field is 32 or more changes no register. This covers an address whose low five bits alias a valid register and an address with only its top bit set.
- R6: A read address of 32 or more returns 32'h0000_0000 on the read-data output.
- R7: When a read and a write to the same register fall in the same cycle, the read returns the old value. The new value is returned one clock later.
- R8: A synchronous active-high reset clears every register and the read-data output to zero.
- R9: Starting from reset, register 1 reads 32'h0000_0000. After the write word 64'h0000_0001_FFFF_FFFF is applied, register 1 reads 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrWord | input | 64 | Packed write command: address in 63:32, data in 31:0 |
| rdAddr | input | 32 | Read register address |
| rdData | output | 32 | Registered read data |

## Verification
The hardest case to reach from the ports is the power-up write word. It must be ignored, and the only sign that it was ignored is a register that stays at zero. To get there, the stimulus holds a valid, nonzero write command across the release of reset and then reads back the target register. A second such check holds a word that was already written across a mid-run reset. Read-during-write ordering is reached by changing the write word and the read address on the same falling edge. The data output is then sampled on the next two falling edges.

// File: rtl/probe_regbank_pkg.sv
package probe_regbank_pkg;

  localparam int DEF_NUM_REGS = 32;
  localparam int DEF_ADDR_W   = 32;
  localparam int DEF_DATA_W   = 32;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic wrChanged;  // word differs from the previous sample
    logic wrCommit;   // changed and address in range
    logic rdInRange;  // read address selects a real register
  } ctrl_strb_t;

endpackage

// File: rtl/probe_regbank_ctrl.sv
module probe_regbank_ctrl
  import probe_regbank_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int DATA_W   = DEF_DATA_W,
  localparam int WORD_W  = ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrl_strb_t        strb
);

  localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(NUM_REGS);

  logic [WORD_W-1:0] prevWord;
  logic              primed;
  logic [ADDR_W-1:0] wrAddr;
  logic              wrInRange;

  assign wrAddr    = wrWord[WORD_W-1:DATA_W];
  assign wrInRange = (wrAddr < ADDR_LIMIT);

  // Reference sample: the first post-reset edge only loads prevWord
  always_ff @(posedge clk) begin
    if (rst) begin
      primed   <= 1'b0;
      prevWord <= wrWord;
    end else begin
      primed   <= 1'b1;
      prevWord <= wrWord;
    end
  end

  always_comb begin
    strb.wrChanged = primed && (wrWord != prevWord);
    strb.wrCommit  = strb.wrChanged && wrInRange;
    strb.rdInRange = (rdAddr < ADDR_LIMIT);
  end

endmodule

// File: rtl/probe_regbank_dp.sv
module probe_regbank_dp
  import probe_regbank_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int DATA_W   = DEF_DATA_W,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strb_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] regFile [NUM_REGS];

  // One storage slot per register, each with its own decoded enable
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic slotWe;
    assign slotWe = strb.wrCommit && (wrIdx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)         regFile[g] <= '0;
      else if (slotWe) regFile[g] <= wrData;
    end
  end

  // Registered read; a same-edge write is seen on the following cycle
  always_ff @(posedge clk) begin
    if (rst)                 rdData <= '0;
    else if (strb.rdInRange) rdData <= regFile[rdIdx];
    else                     rdData <= '0;
  end

endmodule

// File: rtl/probe_regbank.sv
module probe_regbank
  import probe_regbank_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int DATA_W   = DEF_DATA_W,
  localparam int WORD_W  = ADDR_W + DATA_W,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  ctrl_strb_t       ctrlStrb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;

  assign wrIdx = wrWord[DATA_W +: IDX_W];
  assign rdIdx = rdAddr[IDX_W-1:0];

  probe_regbank_ctrl #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrWord(wrWord), .rdAddr(rdAddr), .strb(ctrlStrb)
  );

  probe_regbank_dp #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(ctrlStrb), .wrIdx(wrIdx),
    .wrData(wrWord[DATA_W-1:0]), .rdIdx(rdIdx), .rdData(rdData)
  );

endmodule

// File: rtl/probe_regbank_chk.sv
module probe_regbank_chk
  import probe_regbank_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int DATA_W   = DEF_DATA_W,
  localparam int WORD_W  = ADDR_W + DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] wrWord,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input ctrl_strb_t        strb
);

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  p_held_no_commit_r3: assert property (@(posedge clk) disable iff (rst)
    $stable(wrWord) |-> !strb.wrCommit);

  p_commit_needs_change_r3: assert property (@(posedge clk) disable iff (rst)
    strb.wrCommit |-> (wrWord != $past(wrWord)));

  p_first_sample_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !strb.wrChanged);

  p_oor_write_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    strb.wrCommit |-> (wrWord[WORD_W-1:DATA_W] < LIMIT));

  p_oor_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rdAddr >= LIMIT) |=> (rdData == '0));

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (rdData == '0));

endmodule

bind probe_regbank probe_regbank_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wrWord(wrWord), .rdAddr(rdAddr),
  .rdData(rdData), .strb(ctrlStrb)
);

// File: tb/tb_probe_regbank.sv
`timescale 1ns/1ps
module tb_probe_regbank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] wrWord = 64'h0000_0003_DEAD_BEEF;
  logic [31:0] rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  probe_regbank dut (.clk(clk), .rst(rst), .wrWord(wrWord), .rdAddr(rdAddr), .rdData(rdData));

  localparam int NV = 11;
  localparam logic [63:0] V_WR [NV] = '{
    64'h0000_0001_FFFF_FFFF, 64'h0000_001F_1234_5678, 64'h0000_0000_A5A5_A5A5,
    64'h0000_0001_0000_0042, 64'h0000_0020_CAFE_F00D, 64'h0000_0021_1111_1111,
    64'h8000_0002_2222_2222, 64'h0000_0002_3333_3333, 64'h0000_0002_3333_3333,
    64'h0000_0002_3333_3333, 64'h0000_0002_3333_3333};
  localparam logic [31:0] V_RA [NV] = '{
    32'd1, 32'd31, 32'd0, 32'd1, 32'd0, 32'd1, 32'd2, 32'd2, 32'd2,
    32'h20, 32'hFFFF_FFFF};
  localparam logic [31:0] V_EX [NV] = '{
    32'hFFFF_FFFF, 32'h1234_5678, 32'hA5A5_A5A5, 32'h0000_0042, 32'hA5A5_A5A5,
    32'h0000_0042, 32'h0000_0000, 32'h3333_3333, 32'h3333_3333, 32'h0, 32'h0};

  function automatic string vecTag(int i);
    case (i)
      0: return "R9";
      1, 2: return "R1";
      3, 7: return "R3";
      4, 5, 6: return "R5";
      8: return "R3 held";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdData=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic applyWrite(input logic [63:0] w);
    @(negedge clk) wrWord = w;
    @(negedge clk);
  endtask

  task automatic readCheck(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk) rdAddr = a;
    @(negedge clk) check(rdData, exp, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rdData, 32'h0, "R8 reset state");
    @(negedge clk) rst = 1'b0;       // word 3/DEADBEEF held across release
    repeat (2) @(negedge clk);
    readCheck(32'd3, 32'h0, "R4 power-up word not written");
    readCheck(32'd1, 32'h0, "R9 before write");

    for (int i = 0; i < NV; i++) begin
      applyWrite(V_WR[i]);
      readCheck(V_RA[i], V_EX[i], vecTag(i));
    end

    // R2: registered read latency
    readCheck(32'd31, 32'h1234_5678, "R2 setup");
    @(negedge clk) rdAddr = 32'd0;
    #1 check(rdData, 32'h1234_5678, "R2 old value before edge");
    @(negedge clk) check(rdData, 32'hA5A5_A5A5, "R2 new value after edge");

    // R7: read and write to the same register in one cycle
    readCheck(32'd5, 32'h0, "R7 setup");
    @(negedge clk) begin wrWord = 64'h0000_0005_7777_0005; rdAddr = 32'd5; end
    @(negedge clk) check(rdData, 32'h0, "R7 old value same cycle");
    @(negedge clk) check(rdData, 32'h7777_0005, "R7 new value next cycle");

    // R8 + R4: mid-run reset with a written word held across it
    @(negedge clk) begin rst = 1'b1; wrWord = 64'h0000_0002_3333_3333; end
    repeat (2) @(negedge clk);
    check(rdData, 32'h0, "R8 rdData during reset");
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
    readCheck(32'd2, 32'h0, "R4 held word after reset");
    readCheck(32'd31, 32'h0, "R8 reg31 cleared");
    readCheck(32'd0, 32'h0, "R8 reg0 cleared");
    readCheck(32'd1, 32'h0, "R8 reg1 cleared");
    applyWrite(64'h0000_0001_FFFF_FFFF);
    readCheck(32'd1, 32'hFFFF_FFFF, "R9 write after reset");

    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishRun();
  end

endmodule